// File: doc/BRIEF.md
# Frequency Configuration Word Bank

This block is a small register bank on an internal byte-wide bus. It holds four 48-bit synthesizer configuration words and a two-bit word selector. One word is live at a time, and the block drives it to a synthesizer control port. Any of the other three words can be rewritten over the bus without disturbing the live output.

A write to the selector register only stages a new choice. The choice takes effect when the bus transaction ends, which the bus interface marks with a one-cycle end-of-transaction strobe. If the committed choice differs from the live one, the block raises a one-cycle reload request so the synthesizer re-acquires the new setting.

Reset restores every word and the selector from constant parameters. Nothing written over the bus survives a reset. Every mapped byte can be read back, and unmapped addresses read as zero.

Top module: `freq_cfg_bank`

## Requirements
- R1: After reset `activeSel` equals `DEFAULT_SEL`, `synthWord` equals the default of that word, `reloadReq` is 0, and reading 8'h40 returns `DEFAULT_SEL` in bits [1:0].
- R2: Word w occupies bus addresses 8'h10+6w through 8'h15+6w, and byte b of the word sits at offset b. A write to a byte of a word that is not active reads back the written value.
- R3: `synthWord` equals the active word, with the byte at its lowest address in bits [47:40] and the byte at its highest address in bits [7:0].
- R4: A write to 8'h40 stages bits [1:0] of the data as the pending selector (0 picks word 0, 1 word 1, 2 word 2, 3 word 3). Reading 8'h40 returns the pending selector in bits [1:0], and bits [7:2] always read 0, whatever was written to them.
- R5: `activeSel` and `synthWord` keep their values after a selector write until a cycle with `busStop` high. After that clock edge, `activeSel` takes the pending value.
- R6: `reloadReq` is high for exactly the one cycle after a `busStop` edge that changed `activeSel`. A `busStop` that commits the same selector produces no pulse.
- R7: A write to any byte of the currently active word is ignored: its read-back value and `synthWord` stay unchanged.
- R8: Reads of addresses outside 8'h10–8'h27 and 8'h40 return 0, and writes to them change no mapped byte.
- R9: A reset after bus writes restores every word byte and the selector to the parameter defaults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| busAddr | input | 8 | Byte address for reads and writes |
| busWrData | input | 8 | Write data |
| busWrEn | input | 1 | Write strobe, one byte per cycle |
| busStop | input | 1 | One-cycle end-of-transaction strobe |
| busRdData | output | 8 | Combinational read data for busAddr |
| synthWord | output | 48 | Active configuration word to the synthesizer |
| activeSel | output | 2 | Index of the active word |
| reloadReq | output | 1 | One-cycle synthesizer reload request |

## Verification
The hardest situation to reach is the interaction between the write lock and a selector change. A word that was locked must become writable once it stops being active, and the newly active word must become locked. The stimulus reaches this in stages. It first edits the three non-active words through the vector table. It then stages and commits a switch to word 0 and checks that word 2 now accepts writes while word 0 rejects them. Separate cycles also separate a staged selector from a committed one, and a STOP that commits an unchanged selector is checked for the absence of a reload pulse.

// File: rtl/freq_cfg_pkg.sv
package freq_cfg_pkg;

  // Decoded bus access handed from control to datapath
  typedef struct packed {
    logic       hitWord;   // address falls in the word region
    logic       hitSel;    // address is the selector register
    logic       wordWe;    // accepted write into a word byte
    logic [7:0] wordIdx;   // word index of the address
    logic [7:0] byteIdx;   // byte offset inside the word
  } cfgStrobe_t;

endpackage

// File: rtl/freq_cfg_ctrl.sv
module freq_cfg_ctrl
  import freq_cfg_pkg::*;
#(
  parameter int NUM_WORDS   = 4,
  parameter int BPW         = 6,
  parameter int WORD_BASE   = 'h10,
  parameter int SEL_ADDR    = 'h40,
  parameter int SEL_W       = $clog2(NUM_WORDS),
  parameter logic [SEL_W-1:0] DEFAULT_SEL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       busAddr,
  input  logic [SEL_W-1:0] selData,
  input  logic             busWrEn,
  input  logic             busStop,
  output cfgStrobe_t       strb,
  output logic [SEL_W-1:0] pendSel,
  output logic [SEL_W-1:0] activeSel,
  output logic             reloadReq
);

  localparam int WORD_END = WORD_BASE + NUM_WORDS * BPW;

  logic [7:0] offset;
  logic       inWords;
  logic       inSel;
  logic [7:0] wIdx;
  logic [7:0] bIdx;

  always_comb begin
    inWords = (int'(busAddr) >= WORD_BASE) && (int'(busAddr) < WORD_END);
    inSel   = (int'(busAddr) == SEL_ADDR);
    offset  = busAddr - 8'(WORD_BASE);
    wIdx    = 8'(int'(offset) / BPW);
    bIdx    = 8'(int'(offset) % BPW);
  end

  // Writes aimed at the live word are refused so the output never tears
  always_comb begin
    strb.hitWord = inWords;
    strb.hitSel  = inSel;
    strb.wordIdx = wIdx;
    strb.byteIdx = bIdx;
    strb.wordWe  = busWrEn && inWords && (wIdx != 8'(activeSel));
  end

  // Staged selector: reserved upper bits never reach storage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pendSel <= DEFAULT_SEL;
    else if (busWrEn && inSel) pendSel <= selData;
  end

  // Commit on end of transaction; pulse reload only on a real change
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      activeSel <= DEFAULT_SEL;
      reloadReq <= 1'b0;
    end else if (busStop && (pendSel != activeSel)) begin
      activeSel <= pendSel;
      reloadReq <= 1'b1;
    end else begin
      reloadReq <= 1'b0;
    end
  end

endmodule

// File: rtl/freq_cfg_data.sv
module freq_cfg_data
  import freq_cfg_pkg::*;
#(
  parameter int NUM_WORDS = 4,
  parameter int BPW       = 6,
  parameter int SEL_W     = $clog2(NUM_WORDS),
  parameter logic [NUM_WORDS*BPW*8-1:0] DEFAULT_WORDS = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  cfgStrobe_t         strb,
  input  logic [7:0]         busWrData,
  input  logic [SEL_W-1:0]   pendSel,
  input  logic [SEL_W-1:0]   activeSel,
  output logic [7:0]         busRdData,
  output logic [BPW*8-1:0]   synthWord
);

  // Byte 0 of each word is the most significant, matching output order
  logic [NUM_WORDS-1:0][0:BPW-1][7:0] cells;
  logic [NUM_WORDS-1:0][BPW*8-1:0]    wordVec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cells <= DEFAULT_WORDS;
    end else if (strb.wordWe) begin
      for (int w = 0; w < NUM_WORDS; w++) begin
        for (int b = 0; b < BPW; b++) begin
          if (strb.wordIdx == 8'(w) && strb.byteIdx == 8'(b))
            cells[w][b] <= busWrData;
        end
      end
    end
  end

  for (genvar g = 0; g < NUM_WORDS; g++) begin : gWord
    assign wordVec[g] = cells[g];
  end

  assign synthWord = wordVec[activeSel];

  always_comb begin
    busRdData = 8'h00;
    if (strb.hitWord) begin
      for (int w = 0; w < NUM_WORDS; w++) begin
        for (int b = 0; b < BPW; b++) begin
          if (strb.wordIdx == 8'(w) && strb.byteIdx == 8'(b))
            busRdData = cells[w][b];
        end
      end
    end else if (strb.hitSel) begin
      busRdData = 8'(pendSel);
    end
  end

endmodule

// File: rtl/freq_cfg_bank.sv
module freq_cfg_bank
  import freq_cfg_pkg::*;
#(
  parameter int NUM_WORDS = 4,
  parameter int BPW       = 6,
  parameter int WORD_BASE = 'h10,
  parameter int SEL_ADDR  = 'h40,
  parameter int SEL_W     = $clog2(NUM_WORDS),
  parameter logic [NUM_WORDS*BPW*8-1:0] DEFAULT_WORDS =
    {48'hC1C2C3C4C5C6, 48'hB1B2B3B4B5B6, 48'hA1A2A3A4A5A6, 48'h102030405060},
  parameter logic [SEL_W-1:0] DEFAULT_SEL = 2'd2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       busAddr,
  input  logic [7:0]       busWrData,
  input  logic             busWrEn,
  input  logic             busStop,
  output logic [7:0]       busRdData,
  output logic [BPW*8-1:0] synthWord,
  output logic [SEL_W-1:0] activeSel,
  output logic             reloadReq
);

  cfgStrobe_t       strb;
  logic [SEL_W-1:0] pendSel;

  freq_cfg_ctrl #(
    .NUM_WORDS(NUM_WORDS), .BPW(BPW), .WORD_BASE(WORD_BASE),
    .SEL_ADDR(SEL_ADDR), .SEL_W(SEL_W), .DEFAULT_SEL(DEFAULT_SEL)
  ) uCtrl (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr),
    .selData(busWrData[SEL_W-1:0]), .busWrEn(busWrEn), .busStop(busStop),
    .strb(strb), .pendSel(pendSel), .activeSel(activeSel),
    .reloadReq(reloadReq)
  );

  freq_cfg_data #(
    .NUM_WORDS(NUM_WORDS), .BPW(BPW), .SEL_W(SEL_W),
    .DEFAULT_WORDS(DEFAULT_WORDS)
  ) uData (
    .clk(clk), .rst_n(rst_n), .strb(strb), .busWrData(busWrData),
    .pendSel(pendSel), .activeSel(activeSel),
    .busRdData(busRdData), .synthWord(synthWord)
  );

endmodule

// File: rtl/freq_cfg_bank_chk.sv
module freq_cfg_bank_chk #(
  parameter int NUM_WORDS = 4,
  parameter int BPW       = 6,
  parameter int WORD_BASE = 'h10,
  parameter int SEL_ADDR  = 'h40,
  parameter int SEL_W     = $clog2(NUM_WORDS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [7:0]       busAddr,
  input logic             busWrEn,
  input logic             busStop,
  input logic [7:0]       busRdData,
  input logic [BPW*8-1:0] synthWord,
  input logic [SEL_W-1:0] activeSel,
  input logic             reloadReq
);

  localparam int WORD_END = WORD_BASE + NUM_WORDS * BPW;

  int   liveLo;
  logic inLive;
  logic mapped;

  always_comb begin
    liveLo = WORD_BASE + int'(activeSel) * BPW;
    inLive = (int'(busAddr) >= liveLo) && (int'(busAddr) < liveLo + BPW);
    mapped = ((int'(busAddr) >= WORD_BASE) && (int'(busAddr) < WORD_END)) ||
             (int'(busAddr) == SEL_ADDR);
  end

  assert_sel_only_on_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (activeSel != $past(activeSel)) |-> $past(busStop));

  assert_reload_means_change_R6: assert property (@(posedge clk) disable iff (!rst_n)
    reloadReq |-> (activeSel != $past(activeSel)));

  assert_reload_after_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    reloadReq |-> $past(busStop));

  assert_live_word_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busWrEn && inLive && !busStop) |-> $stable(synthWord));

  assert_reserved_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(busAddr) == SEL_ADDR) |-> (busRdData[7:SEL_W] == '0));

  assert_unmapped_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !mapped |-> (busRdData == 8'h00));

endmodule

bind freq_cfg_bank freq_cfg_bank_chk #(
  .NUM_WORDS(NUM_WORDS), .BPW(BPW), .WORD_BASE(WORD_BASE),
  .SEL_ADDR(SEL_ADDR), .SEL_W(SEL_W)
) uChk (
  .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWrEn(busWrEn),
  .busStop(busStop), .busRdData(busRdData), .synthWord(synthWord),
  .activeSel(activeSel), .reloadReq(reloadReq)
);

// File: tb/freq_cfg_bank_test.sv
module freq_cfg_bank_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  busAddr = 8'h00;
  logic [7:0]  busWrData = 8'h00;
  logic        busWrEn = 1'b0;
  logic        busStop = 1'b0;
  logic [7:0]  busRdData;
  logic [47:0] synthWord;
  logic [1:0]  activeSel;
  logic        reloadReq;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  freq_cfg_bank uut (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWrData(busWrData),
    .busWrEn(busWrEn), .busStop(busStop), .busRdData(busRdData),
    .synthWord(synthWord), .activeSel(activeSel), .reloadReq(reloadReq)
  );

  // {requirement number, address, write data, expected read-back}
  // Active word is 2 (8'h1C..8'h21) throughout this table.
  localparam int NVEC = 15;
  localparam logic [27:0] VEC [NVEC] = '{
    {4'd2, 8'h10, 8'h55, 8'h55},  // R2 word 0 first byte
    {4'd2, 8'h15, 8'h66, 8'h66},  // R2 word 0 last byte
    {4'd2, 8'h16, 8'h77, 8'h77},  // R2 word 1 first byte
    {4'd2, 8'h1B, 8'h88, 8'h88},  // R2 word 1 last byte
    {4'd2, 8'h22, 8'h99, 8'h99},  // R2 word 3 first byte
    {4'd2, 8'h27, 8'hAA, 8'hAA},  // R2 word 3 last byte
    {4'd7, 8'h1C, 8'h00, 8'hB1},  // R7 live word first byte refused
    {4'd7, 8'h21, 8'h00, 8'hB6},  // R7 live word last byte refused
    {4'd4, 8'h40, 8'hFF, 8'h03},  // R4 reserved bits dropped
    {4'd4, 8'h40, 8'h02, 8'h02},  // R4 stage back to word 2
    {4'd8, 8'h30, 8'h12, 8'h00},  // R8 gap
    {4'd8, 8'h0F, 8'h34, 8'h00},  // R8 below words
    {4'd8, 8'h28, 8'h56, 8'h00},  // R8 just past words
    {4'd8, 8'h3F, 8'h78, 8'h00},  // R8 below selector
    {4'd8, 8'h41, 8'h9A, 8'h00}   // R8 above selector
  };

  task automatic check(input string req, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdData;
  endtask

  task automatic endTxn();
    @(negedge clk);
    busStop = 1'b1;
    @(negedge clk);
    busStop = 1'b0;
    #1;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    check("R1 activeSel", 48'(activeSel), 48'd2);
    check("R1 synthWord", synthWord, 48'hB1B2B3B4B5B6);
    check("R1 reloadReq", 48'(reloadReq), 48'd0);
    busRead(8'h40, rd);
    check("R1 select readback", 48'(rd), 48'h02);

    for (int i = 0; i < NVEC; i++) begin
      busWrite(VEC[i][23:16], VEC[i][15:8]);
      busRead(VEC[i][23:16], rd);
      checks++;
      if (rd !== VEC[i][7:0]) begin
        errors++;
        $display("FAIL R%0d addr=%h actual=%h expected=%h",
                 VEC[i][27:24], VEC[i][23:16], rd, VEC[i][7:0]);
      end
    end

    check("R3 live word after table", synthWord, 48'hB1B2B3B4B5B6);
    check("R8 no reload from table", 48'(reloadReq), 48'd0);

    // Stage word 0 without commit
    busWrite(8'h40, 8'h00);
    #1;
    check("R5 staged not live", 48'(activeSel), 48'd2);
    check("R5 output held", synthWord, 48'hB1B2B3B4B5B6);
    endTxn();
    check("R6 reload pulse", 48'(reloadReq), 48'd1);
    check("R5 committed", 48'(activeSel), 48'd0);
    check("R3 byte order word 0", synthWord, 48'h552030405066);
    @(negedge clk); #1;
    check("R6 pulse one cycle", 48'(reloadReq), 48'd0);

    endTxn();
    check("R6 same selector no pulse", 48'(reloadReq), 48'd0);

    // Lock follows the active word
    busWrite(8'h1C, 8'hEE);
    busRead(8'h1C, rd);
    check("R2 former live word writable", 48'(rd), 48'hEE);
    busWrite(8'h11, 8'h00);
    busRead(8'h11, rd);
    check("R7 new live word locked", 48'(rd), 48'h20);
    check("R7 output unchanged", synthWord, 48'h552030405066);

    busWrite(8'h40, 8'h03);
    endTxn();
    check("R6 reload to word 3", 48'(reloadReq), 48'd1);
    check("R3 word 3 output", synthWord, 48'h99C2C3C4C5AA);

    // R9 reset restores defaults
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R9 activeSel", 48'(activeSel), 48'd2);
    check("R9 synthWord", synthWord, 48'hB1B2B3B4B5B6);
    busRead(8'h10, rd);
    check("R9 word 0 byte", 48'(rd), 48'h10);
    busRead(8'h27, rd);
    check("R9 word 3 byte", 48'(rd), 48'hC6);
    busRead(8'h40, rd);
    check("R9 selector", 48'(rd), 48'h02);

    finishRun();
  end

endmodule